// File: doc/BRIEF.md
# SPI Flash Command Engine

This block issues one short command at a time to a single serial flash device. It uses SPI mode 0 and one chip select. Software fills a command register and a 32-bit data register. The command register holds the opcode byte and a 24-bit address. Software then writes the control register with a transmit byte count, a receive byte count and the start bit. The engine drops chip select and clocks out the counted transmit bytes. It then clocks in the counted receive bytes and packs them into the data register. Finally it raises chip select again and clears its busy flag.

The transmit stream comes from fixed register fields in a fixed order. The opcode is sent first. The address follows, most significant byte first. The data bytes come last, low byte first. The transmit count takes a prefix of this stream, so a short command is formed by a smaller count. Every byte goes out and comes in most significant bit first. The serial clock runs at the system clock divided by `2*HALF_DIV`.

Top module: `spi_cmd_engine`

## Requirements
- R1: Register map on `reg_addr_i`. Address 0 is the control register: transmit count in bits 3:0, receive count in bits 7:4, start in bit 8 and busy in bit 16. The start bit always reads 0. Address 1 is the command register: opcode in bits 7:0 and address in bits 31:8. Address 2 is the data register. Address 3 reads 0. Register writes are captured on the clock edge where `reg_we_i` is 1, and reads are combinational.
- R2: A control write with bit 8 set, made while idle, launches a command. Chip select goes low in the cycle after the write edge. A command with both counts 0 keeps chip select high.
- R3: The transmit stream is, in order: the opcode, address bits 31:24, 23:16 and 15:8 of the command register, then data bytes 7:0, 15:8, 23:16 and 31:24. The first transmit-count bytes of this stream are sent, each MSB first.
- R4: The received bytes follow the transmit bytes. Byte j goes into data register bits 8j+7:8j, and each byte is shifted in MSB first. Data bytes at or above the receive count are left unchanged. MISO has no effect while transmit bytes are being sent.
- R5: Mode 0 timing. SCLK idles low, one period is 2*HALF_DIV clocks and there are 8*(tx+rx) pulses per command. MOSI changes only while SCLK is low, and MISO is sampled on the SCLK rising edge.
- R6: Chip select stays low from launch until HALF_DIV cycles after the last falling SCLK edge. It then stays high for 2*HALF_DIV cycles before busy clears.
- R7: Busy reads 1 from the cycle after launch until completion. The command takes (2*8*(tx+rx)+3)*HALF_DIV cycles.
- R8: While busy, writes to every register are ignored, including a start.
- R9: A written transmit count above 8 is stored as 8, and a receive count above 4 is stored as 4.
- R10: After reset all registers read 0, chip select is high, and SCLK and MOSI are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| spi_sclk_o | output | 1 | Serial clock, idle low |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the device |
| spi_miso_i | input | 1 | Serial data from the device |

## Verification
The bench builds the engine with HALF_DIV=3. Each SCLK phase and the chip-select lead, trail and gap windows are then several cycles long. An off-by-one in the phase counter therefore moves a pin edge that the per-cycle model detects. The commands run up to 8 transmit and 4 receive bytes, which reaches the full 96-bit frame. They also include a zero-length command and back-to-back launches. Writes made while a command is in flight check that the register file stays frozen.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 32;
  localparam int REG_AW   = 2;
  localparam int CNT_W    = 4;
  localparam int MAX_TX   = 8;
  localparam int MAX_RX   = 4;
  localparam int TXC_LSB  = 0;
  localparam int RXC_LSB  = 4;
  localparam int START_BIT = 8;
  localparam int BUSY_BIT = 16;

  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_CMD  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_DATA = 2'd2;

  typedef enum logic [2:0] {
    SH_IDLE,
    SH_LEAD,
    SH_SHIFT,
    SH_TRAIL,
    SH_GAP
  } sh_state_e;
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              go_o,
  output logic [CNT_W-1:0]  go_tx_o,
  output logic [CNT_W-1:0]  go_rx_o,
  output logic [CNT_W-1:0]  tx_cnt_o,
  output logic [CNT_W-1:0]  rx_cnt_o,
  output logic [WORD_W-1:0] cmd_o,
  output logic [WORD_W-1:0] data_o
);
  logic [WORD_W-1:0] cmd_q, data_q;
  logic [CNT_W-1:0]  tx_q, rx_q;
  logic              wr_ok;

  function automatic logic [CNT_W-1:0] sat(input logic [CNT_W-1:0] v,
                                           input logic [CNT_W-1:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  assign wr_ok   = we_i & ~busy_i;
  assign go_tx_o = sat(wdata_i[TXC_LSB +: CNT_W], CNT_W'(MAX_TX));
  assign go_rx_o = sat(wdata_i[RXC_LSB +: CNT_W], CNT_W'(MAX_RX));
  assign go_o    = wr_ok && (addr_i == ADDR_CTRL) && wdata_i[START_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      data_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (done_i) begin
      // merge only the bytes the command received
      for (int j = 0; j < MAX_RX; j++) begin
        if (CNT_W'(j) < rx_q) data_q[BYTE_W*j +: BYTE_W] <= rx_word_i[BYTE_W*j +: BYTE_W];
      end
    end else if (wr_ok) begin
      case (addr_i)
        ADDR_CTRL: begin
          tx_q <= go_tx_o;
          rx_q <= go_rx_o;
        end
        ADDR_CMD:  cmd_q  <= wdata_i;
        ADDR_DATA: data_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[TXC_LSB +: CNT_W] = tx_q;
        rdata_o[RXC_LSB +: CNT_W] = rx_q;
        rdata_o[BUSY_BIT]         = busy_i;
      end
      ADDR_CMD:  rdata_o = cmd_q;
      ADDR_DATA: rdata_o = data_q;
      default:   rdata_o = '0;
    endcase
  end

  assign tx_cnt_o = tx_q;
  assign rx_cnt_o = rx_q;
  assign cmd_o    = cmd_q;
  assign data_o   = data_q;
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [CNT_W-1:0]  go_tx_i,
  input  logic [CNT_W-1:0]  go_rx_i,
  input  logic [WORD_W-1:0] cmd_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              cs_no,
  output logic              mosi_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_word_o
);
  localparam int STREAM_W = BYTE_W * MAX_TX;
  localparam int SEL_W    = $clog2(STREAM_W);
  localparam int BIT_W    = $clog2(BYTE_W * (MAX_TX + MAX_RX) + 1);
  localparam int TICK_W   = $clog2(2 * HALF_DIV);
  localparam int RXJ_W    = $clog2(MAX_RX);
  localparam int DBYTES   = WORD_W / BYTE_W;

  sh_state_e            state_q;
  logic [TICK_W-1:0]    tick_q, lim;
  logic [BIT_W-1:0]     bit_idx_q, tx_bits, total_bits, last_bit;
  logic [CNT_W-1:0]     tx_q, rx_q;
  logic                 sclk_q, cs_n_q, ev, sample_now, go_any;
  logic [STREAM_W-1:0]  stream;
  logic [SEL_W-1:0]     sel;
  logic [RXJ_W-1:0]     rx_j;
  logic [BYTE_W-2:0]    rx_byte_q;
  logic [WORD_W-1:0]    rx_word_q;

  // opcode, address MSB first, then data bytes low byte first
  always_comb begin
    stream = '0;
    stream[STREAM_W-1 -: BYTE_W] = cmd_i[BYTE_W-1:0];
    stream[STREAM_W-BYTE_W-1 -: (WORD_W-BYTE_W)] = cmd_i[WORD_W-1:BYTE_W];
    for (int k = 0; k < DBYTES; k++)
      stream[WORD_W-1-BYTE_W*k -: BYTE_W] = data_i[BYTE_W*k +: BYTE_W];
  end

  assign tx_bits    = BIT_W'({tx_q, 3'b000});
  assign total_bits = tx_bits + BIT_W'({rx_q, 3'b000});
  assign last_bit   = total_bits - 1'b1;
  assign go_any     = (|go_tx_i) | (|go_rx_i);
  assign lim        = (state_q == SH_GAP) ? TICK_W'(2*HALF_DIV-1) : TICK_W'(HALF_DIV-1);
  assign ev         = (tick_q == lim);
  assign sample_now = ev && ((state_q == SH_LEAD) || (state_q == SH_SHIFT && !sclk_q));
  assign sel        = SEL_W'(STREAM_W-1) - bit_idx_q[SEL_W-1:0];
  assign rx_j       = RXJ_W'(bit_idx_q[BIT_W-1:3] - tx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SH_IDLE;
      tick_q    <= '0;
      bit_idx_q <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
      sclk_q    <= 1'b0;
      cs_n_q    <= 1'b1;
    end else begin
      if (state_q != SH_IDLE) tick_q <= ev ? '0 : tick_q + 1'b1;
      case (state_q)
        SH_IDLE: if (go_i) begin
          tx_q      <= go_tx_i;
          rx_q      <= go_rx_i;
          bit_idx_q <= '0;
          tick_q    <= '0;
          if (go_any) begin
            state_q <= SH_LEAD;
            cs_n_q  <= 1'b0;
          end else begin
            state_q <= SH_TRAIL;
          end
        end
        SH_LEAD: if (ev) begin
          sclk_q  <= 1'b1;
          state_q <= SH_SHIFT;
        end
        SH_SHIFT: if (ev) begin
          if (sclk_q) begin
            sclk_q <= 1'b0;
            if (bit_idx_q == last_bit) state_q <= SH_TRAIL;
            else bit_idx_q <= bit_idx_q + 1'b1;
          end else begin
            sclk_q <= 1'b1;
          end
        end
        SH_TRAIL: if (ev) begin
          cs_n_q  <= 1'b1;
          state_q <= SH_GAP;
        end
        SH_GAP: if (ev) state_q <= SH_IDLE;
        default: state_q <= SH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_byte_q <= '0;
      rx_word_q <= '0;
    end else if (sample_now && (bit_idx_q >= tx_bits)) begin
      rx_byte_q <= {rx_byte_q[BYTE_W-3:0], miso_i};
      if (&bit_idx_q[2:0]) rx_word_q[BYTE_W*rx_j +: BYTE_W] <= {rx_byte_q, miso_i};
    end
  end

  assign mosi_o    = ((state_q == SH_LEAD) || (state_q == SH_SHIFT)) && (bit_idx_q < tx_bits)
                     ? stream[sel] : 1'b0;
  assign sclk_o    = sclk_q;
  assign cs_no     = cs_n_q;
  assign busy_o    = (state_q != SH_IDLE);
  assign done_o    = (state_q == SH_GAP) && ev;
  assign rx_word_o = rx_word_q;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        spi_sclk_o,
  output logic        spi_cs_no,
  output logic        spi_mosi_o,
  input  logic        spi_miso_i
);
  logic              go_w, busy_w, done_w;
  logic [CNT_W-1:0]  go_tx_w, go_rx_w, tx_w, rx_w;
  logic [WORD_W-1:0] cmd_w, data_w, rx_word_w;

  spi_cmd_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .busy_i    (busy_w),
    .done_i    (done_w),
    .rx_word_i (rx_word_w),
    .go_o      (go_w),
    .go_tx_o   (go_tx_w),
    .go_rx_o   (go_rx_w),
    .tx_cnt_o  (tx_w),
    .rx_cnt_o  (rx_w),
    .cmd_o     (cmd_w),
    .data_o    (data_w)
  );

  spi_cmd_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go_w),
    .go_tx_i   (go_tx_w),
    .go_rx_i   (go_rx_w),
    .cmd_i     (cmd_w),
    .data_i    (data_w),
    .miso_i    (spi_miso_i),
    .sclk_o    (spi_sclk_o),
    .cs_no     (spi_cs_no),
    .mosi_o    (spi_mosi_o),
    .busy_o    (busy_w),
    .done_o    (done_w),
    .rx_word_o (rx_word_w)
  );
endmodule

// File: rtl/spi_cmd_chk.sv
module spi_cmd_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sclk_i,
  input logic        cs_ni,
  input logic        mosi_i,
  input logic        busy_i,
  input logic        done_i,
  input logic        we_i,
  input logic [3:0]  tx_cnt_i,
  input logic [3:0]  rx_cnt_i,
  input logic [31:0] cmd_i,
  input logic [31:0] data_i
);
  // R5
  sclk_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_i |-> !cs_ni);

  // R5
  mosi_low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mosi_i) |-> !sclk_i);

  // R7
  cs_implies_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_ni |-> busy_i);

  // R6
  cs_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_ni) |-> busy_i && !sclk_i);

  // R8
  frozen_regs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && we_i && !done_i |=> $stable(cmd_i) && $stable(data_i)
                                  && $stable(tx_cnt_i) && $stable(rx_cnt_i));

  // R9
  count_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt_i <= 4'd8) && (rx_cnt_i <= 4'd4));
endmodule

bind spi_cmd_engine spi_cmd_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sclk_i   (spi_sclk_o),
  .cs_ni    (spi_cs_no),
  .mosi_i   (spi_mosi_o),
  .busy_i   (busy_w),
  .done_i   (done_w),
  .we_i     (reg_we_i),
  .tx_cnt_i (tx_w),
  .rx_cnt_i (rx_w),
  .cmd_i    (cmd_w),
  .data_i   (data_w)
);

// File: tb/spi_cmd_engine_tb.sv
module spi_cmd_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;

  logic        clk, rst_n, we, miso;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic        sclk, cs_n, mosi;

  spi_cmd_engine #(.HALF_DIV(HALF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .spi_sclk_o(sclk),
    .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  int cyc = 0, e_cyc = 0;
  bit active = 0, cmp_en = 0;
  int m_tx = 0, m_rx = 0, m_n = 0;
  logic [31:0] m_cmd = '0, m_data = '0;
  logic [63:0] m_stream = '0;
  logic [7:0]  reply [4];
  bit cap_on = 0;
  logic [7:0] cap_q[$];
  logic [7:0] cap_byte = '0;
  int cap_bits = 0, rises = 0;
  int hi_run = 0, min_gap = 1000;
  bit seen_low = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int end_t();
    return (2*m_n + 3) * HALF;
  endfunction

  function automatic int sat(input int v, input int lim);
    return (v > lim) ? lim : v;
  endfunction

  // behavioural reference: registers and command timing
  always @(posedge clk) begin : model
    bit busy_b;
    busy_b = active && ((cyc - e_cyc) < end_t());
    cyc++;
    if (!rst_n) begin
      m_tx = 0; m_rx = 0; m_n = 0; m_cmd = '0; m_data = '0; active = 0;
    end else begin
      if (active && (cyc - e_cyc) == end_t()) begin
        for (int j = 0; j < m_rx; j++) m_data[8*j +: 8] = reply[j];
        active = 0;
      end
      if (we && !busy_b) begin
        case (addr)
          2'd0: begin
            m_tx = sat(int'(wdata[3:0]), 8);
            m_rx = sat(int'(wdata[7:4]), 4);
            if (wdata[8]) begin
              m_n = 8 * (m_tx + m_rx);
              m_stream = {m_cmd[7:0], m_cmd[31:8], m_data[7:0], m_data[15:8],
                          m_data[23:16], m_data[31:24]};
              e_cyc = cyc;
              active = 1;
            end
          end
          2'd1: m_cmd = wdata;
          2'd2: m_data = wdata;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison and device model on MISO
  always begin : compare
    int t, q, b, rb;
    bit e_cs, e_sclk, e_mosi, e_busy;
    logic [31:0] e_rd;
    @(negedge clk);
    #1;
    e_cs = 1; e_sclk = 0; e_mosi = 0; e_busy = 0;
    t = 0; q = 0; b = 0;
    if (active) begin
      t = cyc - e_cyc;
      q = t / HALF;
      b = q / 2;
      e_busy = t < end_t();
      if (m_n > 0) begin
        e_cs   = !(t < (2*m_n + 1) * HALF);
        e_sclk = (q % 2 == 1) && (q <= 2*m_n - 1);
        e_mosi = (q < 2*m_n) && (b < 8*m_tx) ? m_stream[63 - b] : 1'b0;
      end
    end
    if (active && m_n > 0 && q < 2*m_n && b >= 8*m_tx) begin
      rb = b - 8*m_tx;
      miso = reply[rb/8][7 - rb%8];
    end else begin
      miso = cyc[0] ^ cyc[2];
    end
    if (rst_n && cmp_en) begin
      chk(cs_n == e_cs, "R6", "chip select", cs_n, e_cs);
      chk(sclk == e_sclk, "R5", "sclk", sclk, e_sclk);
      chk(mosi == e_mosi, "R3", "mosi", mosi, e_mosi);
      case (addr)
        2'd0: e_rd = {15'd0, e_busy, 8'd0, 4'(m_rx), 4'(m_tx)};
        2'd1: e_rd = m_cmd;
        2'd2: e_rd = m_data;
        default: e_rd = '0;
      endcase
      if (addr == 2'd0) chk(rdata == e_rd, "R7", "control readback", rdata, e_rd);
      else if (addr == 2'd2) chk(rdata == e_rd, "R4", "data readback", rdata, e_rd);
      else chk(rdata == e_rd, "R1", "register readback", rdata, e_rd);
      if (cs_n) hi_run++;
      else begin
        if (seen_low && hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
        seen_low = 1;
        hi_run = 0;
      end
    end
  end

  // bench-side capture of transmitted bytes
  always @(posedge sclk) begin
    rises++;
    if (cap_on) begin
      cap_byte = {cap_byte[6:0], mosi};
      cap_bits++;
      if (cap_bits % 8 == 0) cap_q.push_back(cap_byte);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0; addr = 2'd0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #2;
    v = rdata;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (active);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    int r0;
    rst_n = 0; we = 0; addr = '0; wdata = '0; miso = 0;
    foreach (reply[i]) reply[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R10 reset state
    chk(cs_n == 1'b1, "R10", "cs after reset", cs_n, 1);
    chk(sclk == 1'b0, "R10", "sclk after reset", sclk, 0);
    chk(mosi == 1'b0, "R10", "mosi after reset", mosi, 0);
    chk(rdata == 32'h0, "R10", "control after reset", rdata, 0);
    rd(2'd2, v);
    chk(v == 32'h0, "R10", "data after reset", v, 0);
    rd(2'd3, v);
    chk(v == 32'h0, "R1", "unused address", v, 0);
    cmp_en = 1;

    // read: tx=4 (opcode + address), rx=4
    reply[0] = 8'h11; reply[1] = 8'h22; reply[2] = 8'h33; reply[3] = 8'h44;
    wr(2'd1, 32'hABCDEF03);
    wr(2'd0, 32'h0000_0144);
    #1;
    chk(cs_n == 1'b0, "R2", "cs low after launch", cs_n, 0);
    chk(rdata[16] == 1'b1, "R7", "busy after launch", rdata[16], 1);
    chk(rdata[8] == 1'b0, "R1", "start self-clears", rdata[8], 0);
    wait_idle();
    rd(2'd2, v);
    chk(v == 32'h44332211, "R4", "received little-endian", v, 32'h44332211);

    // program: tx=8, rx=0, capture the stream
    wr(2'd2, 32'hDDCCBBAA);
    wr(2'd1, 32'h00102002);
    cap_q.delete(); cap_bits = 0; cap_on = 1; r0 = rises;
    wr(2'd0, 32'h0000_0108);
    wait_idle();
    cap_on = 0;
    chk(rises - r0 == 64, "R5", "sclk pulse count", rises - r0, 64);
    chk(cap_q.size() == 8, "R3", "byte count", cap_q.size(), 8);
    if (cap_q.size() == 8) begin
      chk(cap_q[0] == 8'h02, "R3", "opcode byte", cap_q[0], 8'h02);
      chk(cap_q[1] == 8'h00, "R3", "address high", cap_q[1], 8'h00);
      chk(cap_q[3] == 8'h20, "R3", "address low", cap_q[3], 8'h20);
      chk(cap_q[4] == 8'hAA, "R3", "first data byte", cap_q[4], 8'hAA);
      chk(cap_q[7] == 8'hDD, "R3", "last data byte", cap_q[7], 8'hDD);
    end
    rd(2'd2, v);
    chk(v == 32'hDDCCBBAA, "R4", "no receive keeps data", v, 32'hDDCCBBAA);

    // status read: tx=1, rx=1 merges only byte 0
    reply[0] = 8'h5A;
    wr(2'd1, 32'h00000005);
    wr(2'd0, 32'h0000_0111);
    wait_idle();
    rd(2'd2, v);
    chk(v == 32'hDDCCBB5A, "R4", "partial receive", v, 32'hDDCCBB5A);

    // zero-length command
    wr(2'd0, 32'h0000_0100);
    #1;
    chk(cs_n == 1'b1, "R2", "zero command keeps cs high", cs_n, 1);
    chk(rdata[16] == 1'b1, "R7", "zero command busy", rdata[16], 1);
    wait_idle();

    // count clamp, no start
    wr(2'd0, 32'h0000_00FF);
    rd(2'd0, v);
    chk(v == 32'h00000048, "R9", "clamped counts", v, 32'h48);

    // writes while busy are ignored
    wr(2'd1, 32'h00000006);
    wr(2'd0, 32'h0000_0101);
    wr(2'd2, 32'h12345678);
    wr(2'd1, 32'hFFFFFFFF);
    wr(2'd0, 32'h0000_0144);
    wait_idle();
    rd(2'd2, v);
    chk(v == 32'hDDCCBB5A, "R8", "data frozen while busy", v, 32'hDDCCBB5A);
    rd(2'd1, v);
    chk(v == 32'h00000006, "R8", "command frozen while busy", v, 32'h6);
    rd(2'd0, v);
    chk(v == 32'h00000001, "R8", "counts frozen while busy", v, 32'h1);

    // full frame and back-to-back launches
    reply[0] = 8'hC3; reply[1] = 8'h3C; reply[2] = 8'h81; reply[3] = 8'h7E;
    wr(2'd2, 32'h0F0F0F0F);
    wr(2'd0, 32'h0000_0148);
    do @(negedge clk); while (active);
    wr(2'd0, 32'h0000_0141);
    wait_idle();
    rd(2'd2, v);
    chk(v == 32'h7E813CC3, "R4", "four bytes after one tx", v, 32'h7E813CC3);
    chk(min_gap >= 2*HALF, "R6", "min cs high gap", min_gap, 2*HALF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule